// File: doc/BRIEF.md
# Chained Serial Slot Port

This block is the serial front of a codec-style device that runs as a slave on a shared frame bus. A host supplies a bit clock, a frame-sync line and a serial data line. Several identical devices hang off the same data line. Each device owns exactly one 16-bit slot of the wide frame. The frame sync for the first device comes from the host. Every later device starts its slot from the frame sync that the device before it regenerates. Two devices therefore share a 32-bit frame, and four share a 64-bit frame.

The bit clock, frame sync and serial input are brought into a faster core clock through synchronizers, and the core acts on the bit-clock edges it detects. Incoming bits are sampled on falling bit-clock edges, MSB first. The frame sync is late type: it is high during the same bit period as the slot's first bit. After the sixteenth bit, the captured word is presented with a one-cycle strobe. In the same slot, a 16-bit transmit word is shifted out on rising edges. A tri-state enable is high only while the device drives its slot.

Each slot is also classified as a data frame or a control frame. A control frame is recognised by its timing: a slot that starts half of the frame period (or, in quarter mode, one quarter of it) after the last data slot. A software request can also mark the next slot as control, but only when chaining is off. After chaining is switched on, the first slot is always taken as data, so that the frame timing is re-established.

Top module: `sfs_slot_port`

## Requirements
- R1: While reset is applied, `rx_valid`, `frame_err`, `fs_out` and `sdo_oe` are low and `rx_word` is zero.
- R2: A falling bit-clock edge that sees `fs_in` high samples the slot's first bit. Fifteen more falling edges sample the remaining bits, MSB first. After the sixteenth sample, `rx_word` holds the 16 bits and `rx_valid` is high for exactly one core-clock cycle.
- R3: After `fs_in` rises, `sdo_oe` goes high and `sdo` carries `tx_word` MSB first. A new bit is driven after each rising bit-clock edge. `sdo_oe` falls at the rising edge that ends the sixteenth bit period, so exactly 16 bits are driven.
- R4: With `fwd_en` high, `fs_out` goes high at the rising edge that follows the sixteenth sample and stays high for one bit period. It is therefore high while the bit that follows the slot is sampled.
- R5: While `fwd_en` is low, `fs_out` is low, including when forwarding is switched off during a pending pulse.
- R6: A frame sync sampled while a slot is in progress restarts the slot with the current bit as its first bit, and `frame_err` pulses for one cycle. The word, the forwarded sync and the transmit sequence all follow the restarted slot.
- R7: A slot whose first bit falls N falling edges after the first bit of the last data slot is a control frame when N equals `frame_bits`/2 with `ctl_quarter`=0, or `frame_bits`/4 with `ctl_quarter`=1. Control slots leave that reference point unchanged. `rx_ctl`=1 with `rx_valid` marks a control frame and `rx_ctl`=0 marks a data frame.
- R8: The first slot after `fwd_en` rises is classified as data, even when it sits at the control position.
- R9: A `sw_ctl_req` pulse while `fwd_en` is low marks the next slot as control, and the request is consumed by that slot. A pulse while `fwd_en` is high has no effect.
- R10: While `sdo_oe` is low, `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bit clock from the host |
| fs_in | input | 1 | Late-type frame sync (from the host or the previous device) |
| sdi | input | 1 | Shared serial data line |
| fwd_en | input | 1 | Enables chained operation and frame-sync forwarding |
| ctl_quarter | input | 1 | 0: control slot at half of the frame period, 1: at one quarter |
| frame_bits | input | POS_W | Bit clocks per frame period (96 to 256) |
| sw_ctl_req | input | 1 | Software request to mark the next slot as control |
| tx_word | input | SLOT_W | Word shifted out in the device's own slot |
| sdo | output | 1 | Serial output data |
| sdo_oe | output | 1 | Output enable for an external tri-state buffer on `sdo` |
| fs_out | output | 1 | Regenerated frame sync for the next device |
| rx_word | output | SLOT_W | Last captured slot word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| rx_ctl | output | 1 | High with `rx_valid` when the slot was a control frame |
| frame_err | output | 1 | One-cycle pulse when a frame sync restarts a slot in progress |

## Verification
Two devices are chained, and the second one must capture exactly the 16 bits after the first device's slot. A forwarded sync that came one bit early or late would shift that word by one bit. A frame sync injected five bits into a slot checks the restart. A design that ignored it would deliver the stale word, would forward at bit 16 instead of bit 21, and would not flag the error. The classifier is tested where it is most likely to go wrong: a first-after-enable slot sitting exactly on the control position, a software request in each mode, and the same slot offset in half and quarter mode. A design that got any of these wrong would report a control frame as data or the other way round. Turning forwarding off on the very bit of a pending pulse checks that the output gating does not let one bit period of sync through.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_CTL  = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/sfs_sync.sv
// Multi-stage synchronizer for one asynchronous level (STAGES >= 2).
module sfs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sfs_rx.sv
// Receive slot engine: counts the slot, assembles the word, schedules the forwarded sync.
module sfs_rx #(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic              bit_rise,
  input  logic              fs_lvl,
  input  logic              sd_lvl,
  input  logic              fwd_en,
  output logic [SLOT_W-1:0] word,
  output logic              valid,
  output logic              err,
  output logic              fs_fwd
);
  localparam int CW = $clog2(SLOT_W + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOT_W - 1);

  logic [SLOT_W-1:0] sh_q, sh_d, word_q, word_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              act_q, act_d, valid_q, valid_d, err_q, err_d;
  logic              pend_q, pend_d, fwd_q, fwd_d;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    word_d  = word_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    pend_d  = pend_q;
    fwd_d   = fwd_q;
    if (bit_fall) begin
      if (fs_lvl) begin
        err_d = act_q;
        sh_d  = {sh_q[SLOT_W-2:0], sd_lvl};
        cnt_d = CW'(1);
        act_d = 1'b1;
      end else if (act_q) begin
        sh_d = {sh_q[SLOT_W-2:0], sd_lvl};
        if (cnt_q == LAST) begin
          word_d  = {sh_q[SLOT_W-2:0], sd_lvl};
          valid_d = 1'b1;
          act_d   = 1'b0;
          cnt_d   = '0;
          pend_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
    if (bit_rise) begin
      fwd_d  = pend_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      fwd_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      fwd_q   <= fwd_d;
    end
  end

  assign word   = word_q;
  assign valid  = valid_q;
  assign err    = err_q;
  assign fs_fwd = fwd_q & fwd_en;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R2
  AST_ERR_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(bit_fall && fs_lvl)); // R6
  AST_FWD_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_q) |-> (!act_q && $past(bit_rise))); // R4
endmodule

// File: rtl/sfs_tx.sv
// Transmit slot engine: loads on frame-sync rise, shifts on rising bit-clock edges.
module sfs_tx #(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              fs_rise,
  input  logic [SLOT_W-1:0] tx_word,
  output logic              sdo,
  output logic              oe
);
  localparam int CW = $clog2(SLOT_W);
  localparam logic [CW-1:0] LAST = CW'(SLOT_W - 1);

  logic [SLOT_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              oe_q, oe_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    oe_d  = oe_q;
    if (fs_rise) begin
      sh_d  = tx_word;
      cnt_d = '0;
      oe_d  = 1'b1;
    end else if (bit_rise && oe_q) begin
      if (cnt_q == LAST) begin
        oe_d = 1'b0;
      end else begin
        sh_d  = {sh_q[SLOT_W-2:0], 1'b0};
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo = oe_q & sh_q[SLOT_W-1];
  assign oe  = oe_q;

  AST_TX_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> ($past(cnt_q) == LAST)); // R3
endmodule

// File: rtl/sfs_kind.sv
// Frame classifier: data versus control by slot position, enable sequencing, software request.
module sfs_kind
  import sfs_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_fall,
  input  logic             fs_lvl,
  input  logic             fwd_en,
  input  logic             ctl_quarter,
  input  logic [POS_W-1:0] frame_bits,
  input  logic             sw_req,
  output frame_kind_e      kind
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_d, ctl_pos;
  logic             en_q, first_q, first_d, pend_q, pend_d, start;
  frame_kind_e      kind_q, kind_d;

  assign ctl_pos = ctl_quarter ? (frame_bits >> 2) : (frame_bits >> 1);
  assign start   = bit_fall & fs_lvl;

  always_comb begin
    pos_d   = pos_q;
    first_d = first_q;
    pend_d  = pend_q;
    kind_d  = kind_q;
    if (bit_fall && pos_q != POS_MAX) pos_d = pos_q + POS_W'(1);
    if (start) begin
      if (first_q) begin
        kind_d  = KIND_DATA;
        first_d = 1'b0;
      end else if (pos_q == ctl_pos) begin
        kind_d = KIND_CTL;
      end else if (pend_q && !fwd_en) begin
        kind_d = KIND_CTL;
        pend_d = 1'b0;
      end else begin
        kind_d = KIND_DATA;
      end
      if (kind_d == KIND_DATA) pos_d = POS_W'(1);
    end
    if (fwd_en)      pend_d  = 1'b0;
    else if (sw_req) pend_d  = 1'b1;
    if (fwd_en && !en_q) first_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      en_q    <= 1'b0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
      kind_q  <= KIND_DATA;
    end else begin
      pos_q   <= pos_d;
      en_q    <= fwd_en;
      first_q <= first_d;
      pend_q  <= pend_d;
      kind_q  <= kind_d;
    end
  end

  assign kind = kind_q;

  AST_FIRST_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (start && first_q) |=> (kind_q == KIND_DATA)); // R8
  AST_CTL_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !first_q && pos_q == ctl_pos) |=> (kind_q == KIND_CTL)); // R7
  AST_SW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fwd_en && !first_q && pos_q != ctl_pos) |=> (kind_q == KIND_DATA)); // R9
endmodule

// File: rtl/sfs_slot_port.sv
module sfs_slot_port
  import sfs_pkg::*;
#(
  parameter int SLOT_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fs_in,
  input  logic              sdi,
  input  logic              fwd_en,
  input  logic              ctl_quarter,
  input  logic [POS_W-1:0]  frame_bits,
  input  logic              sw_ctl_req,
  input  logic [SLOT_W-1:0] tx_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              fs_out,
  output logic [SLOT_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_ctl,
  output logic              frame_err
);
  localparam int N_SYNC = 3;

  logic [1:0]        rst_sh_q;
  logic              rst_ni;
  logic [N_SYNC-1:0] raw_v, lvl_v;
  logic              sclk_q, fs_q;
  logic              bit_rise, bit_fall, fs_rise;
  frame_kind_e       kind;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_ni = rst_sh_q[1];

  assign raw_v = {sdi, fs_in, sclk};
  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    sfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_ni),
      .d    (raw_v[g]),
      .q    (lvl_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      sclk_q <= lvl_v[0];
      fs_q   <= lvl_v[1];
    end
  end

  assign bit_rise = lvl_v[0] & ~sclk_q;
  assign bit_fall = ~lvl_v[0] & sclk_q;
  assign fs_rise  = lvl_v[1] & ~fs_q;

  sfs_rx #(.SLOT_W(SLOT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bit_fall(bit_fall),
    .bit_rise(bit_rise),
    .fs_lvl  (lvl_v[1]),
    .sd_lvl  (lvl_v[2]),
    .fwd_en  (fwd_en),
    .word    (rx_word),
    .valid   (rx_valid),
    .err     (frame_err),
    .fs_fwd  (fs_out)
  );

  sfs_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bit_rise(bit_rise),
    .fs_rise (fs_rise),
    .tx_word (tx_word),
    .sdo     (sdo),
    .oe      (sdo_oe)
  );

  sfs_kind #(.POS_W(POS_W)) u_kind (
    .clk        (clk),
    .rst_n      (rst_ni),
    .bit_fall   (bit_fall),
    .fs_lvl     (lvl_v[1]),
    .fwd_en     (fwd_en),
    .ctl_quarter(ctl_quarter),
    .frame_bits (frame_bits),
    .sw_req     (sw_ctl_req),
    .kind       (kind)
  );

  assign rx_ctl = rx_valid & (kind == KIND_CTL);

  AST_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> !fs_out); // R5
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R10
endmodule

// File: tb/sfs_slot_port_test.sv
module sfs_slot_port_test;
  logic        clk = 1'b0;
  logic        rst_n, sclk, fs_in, sdi, fwd_en, ctl_quarter, sw_ctl_req;
  logic [8:0]  frame_bits;
  logic [15:0] tx_word;
  logic        sdo, sdo_oe, fs_out, rx_valid, rx_ctl, frame_err;
  logic [15:0] rx_word;
  logic        dn_sdo, dn_oe, dn_fs_out, dn_valid, dn_ctl, dn_err;
  logic [15:0] dn_word;

  int nchk = 0, nerr = 0;
  int u_cnt, dn_cnt, err_cnt, oe_n, sdo_bad, fso_n;
  logic [15:0] u_words [4];
  logic        u_ctls  [4];
  logic [15:0] dn_words [4];
  logic        dn_ctls  [4];
  logic        u_fso  [128];
  logic        dn_fso [128];
  logic [15:0] tx_cap;

  always #10 clk = ~clk;

  sfs_slot_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_in(fs_in), .sdi(sdi),
    .fwd_en(fwd_en), .ctl_quarter(ctl_quarter), .frame_bits(frame_bits),
    .sw_ctl_req(sw_ctl_req), .tx_word(tx_word), .sdo(sdo), .sdo_oe(sdo_oe),
    .fs_out(fs_out), .rx_word(rx_word), .rx_valid(rx_valid), .rx_ctl(rx_ctl),
    .frame_err(frame_err));

  sfs_slot_port dn (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_in(fs_out), .sdi(sdi),
    .fwd_en(fwd_en), .ctl_quarter(ctl_quarter), .frame_bits(frame_bits),
    .sw_ctl_req(1'b0), .tx_word(16'h0F0F), .sdo(dn_sdo), .sdo_oe(dn_oe),
    .fs_out(dn_fs_out), .rx_word(dn_word), .rx_valid(dn_valid), .rx_ctl(dn_ctl),
    .frame_err(dn_err));

  always @(negedge clk) begin
    if (rx_valid) begin
      if (u_cnt < 4) begin u_words[u_cnt] = rx_word; u_ctls[u_cnt] = rx_ctl; end
      u_cnt++;
    end
    if (dn_valid) begin
      if (dn_cnt < 4) begin dn_words[dn_cnt] = dn_word; dn_ctls[dn_cnt] = dn_ctl; end
      dn_cnt++;
    end
    if (frame_err) err_cnt++;
  end

  function automatic logic dbit(input int b, input int s);
    int v;
    v = b * 5 + s * 3 + b / 4;
    return logic'((v % 3) == 1);
  endfunction

  function automatic logic [15:0] exp_word(input int start, input int s);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 16; i++) w = {w[14:0], dbit(start + i, s)};
    return w;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bitp(input int b, input logic fs, input logic d);
    @(negedge clk);
    sclk = 1'b1; fs_in = fs; sdi = d;
    repeat (5) @(negedge clk);
    u_fso[b]  = fs_out;
    dn_fso[b] = dn_fs_out;
    if (fs_out) fso_n++;
    if (sdo_oe) begin
      oe_n++;
      tx_cap = {tx_cap[14:0], sdo};
    end else if (sdo) sdo_bad++;
    @(negedge clk);
    sclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input int a, input int b2, input int en_bit, input logic en_val, input int s);
    u_cnt = 0; dn_cnt = 0; err_cnt = 0; oe_n = 0; sdo_bad = 0; fso_n = 0; tx_cap = '0;
    for (int b = 0; b < 96; b++) begin
      if (b == en_bit) fwd_en = en_val;
      bitp(b, (b == a) || (b == b2), dbit(b, s));
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_ctl_req = 1'b1;
    @(negedge clk); sw_ctl_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; fs_in = 1'b0; sdi = 1'b0; fwd_en = 1'b0;
    ctl_quarter = 1'b0; sw_ctl_req = 1'b0; frame_bits = 9'd96; tx_word = 16'hA5C3;
    repeat (4) @(negedge clk);
    check_eq("R1", "rx_valid", rx_valid, 0);
    check_eq("R1", "frame_err", frame_err, 0);
    check_eq("R1", "fs_out", fs_out, 0);
    check_eq("R1", "sdo_oe", sdo_oe, 0);
    check_eq("R1", "rx_word", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Standalone frames, varied data and transmit words.
    for (int s = 0; s < 4; s++) begin
      tx_word = 16'hA5C3 ^ 16'(s * 16'h1357);
      frame(0, -1, -1, 1'b0, s);
      check_eq("R2", "slot count", u_cnt, 1);
      check_eq("R2", "captured word", u_words[0], exp_word(0, s));
      check_eq("R7", "plain slot kind", u_ctls[0], 0);
      check_eq("R3", "driven bits", oe_n, 16);
      check_eq("R3", "transmitted word", tx_cap, tx_word);
      check_eq("R5", "fs_out pulses while disabled", fso_n, 0);
      check_eq("R5", "downstream captures", dn_cnt, 0);
      check_eq("R10", "sdo high while not driving", sdo_bad, 0);
      check_eq("R6", "no framing error", err_cnt, 0);
    end

    // Software control request while standalone.
    sw_pulse();
    frame(0, -1, -1, 1'b0, 7);
    check_eq("R9", "sw request standalone kind", u_ctls[0], 1);
    frame(0, -1, -1, 1'b0, 8);
    check_eq("R9", "sw request consumed", u_ctls[0], 0);

    // Enable sequencing: first slot after enable sits on control position.
    frame(48, -1, 70, 1'b1, 9);
    check_eq("R2", "offset slot word", u_words[0], exp_word(48, 9));
    check_eq("R5", "pulse gated before enable", fso_n, 0);
    frame(0, -1, -1, 1'b1, 10);
    check_eq("R8", "first slot after enable kind", u_ctls[0], 0);
    check_eq("R4", "fs_out at bit 16", u_fso[16], 1);
    check_eq("R4", "fs_out one bit only", fso_n, 1);
    check_eq("R8", "downstream first slot kind", dn_ctls[0], 0);

    // Chained frame with a control slot at half.
    frame(0, 48, -1, 1'b1, 11);
    check_eq("R7", "slot count", u_cnt, 2);
    check_eq("R7", "data slot kind", u_ctls[0], 0);
    check_eq("R7", "half control kind", u_ctls[1], 1);
    check_eq("R2", "control word", u_words[1], exp_word(48, 11));
    check_eq("R4", "forward after data slot", u_fso[16], 1);
    check_eq("R4", "forward after control slot", u_fso[64], 1);
    check_eq("R4", "forward pulses", fso_n, 2);
    check_eq("R4", "downstream count", dn_cnt, 2);
    check_eq("R4", "downstream data word", dn_words[0], exp_word(16, 11));
    check_eq("R4", "downstream control word", dn_words[1], exp_word(64, 11));
    check_eq("R7", "downstream control kind", dn_ctls[1], 1);
    check_eq("R4", "downstream forward", dn_fso[32] & dn_fso[80], 1);

    // Software request ignored while chained.
    sw_pulse();
    frame(0, -1, -1, 1'b1, 12);
    check_eq("R9", "sw request ignored when chained", u_ctls[0], 0);

    // Quarter mode versus half mode at offset 24.
    ctl_quarter = 1'b1;
    frame(0, 24, -1, 1'b1, 13);
    check_eq("R7", "quarter data kind", u_ctls[0], 0);
    check_eq("R7", "quarter control kind", u_ctls[1], 1);
    check_eq("R2", "quarter control word", u_words[1], exp_word(24, 13));
    ctl_quarter = 1'b0;
    frame(0, 24, -1, 1'b1, 14);
    check_eq("R7", "offset 24 in half mode is data", u_ctls[1], 0);

    // Restart inside a slot.
    tx_word = 16'h96E1;
    frame(0, 5, -1, 1'b1, 15);
    check_eq("R6", "framing errors", err_cnt, 1);
    check_eq("R6", "slot count", u_cnt, 1);
    check_eq("R6", "restarted word", u_words[0], exp_word(5, 15));
    check_eq("R6", "no forward at 16", u_fso[16], 0);
    check_eq("R6", "forward at 21", u_fso[21], 1);
    check_eq("R6", "driven bits with restart", oe_n, 21);
    check_eq("R6", "restarted transmit word", tx_cap, tx_word);

    // Forwarding switched off on the bit of a pending pulse.
    frame(0, -1, 16, 1'b0, 16);
    check_eq("R5", "fs_out after disable", u_fso[16], 0);
    check_eq("R5", "downstream captures after disable", dn_cnt, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule